// File: doc/BRIEF.md
# Eight-Pin Bidirectional Port with Open-Drain Top Pins

This block is an 8-bit general-purpose pin port attached to a small memory-mapped register bus. Software sets each pin's output value in a data latch and its direction in a direction register. A read of the data address returns a mix: the latch bit for pins set as outputs, and the live level for pins set as inputs. The live levels pass through a two-stage synchronizer first.

A control register applies only to the two highest pins. For each of these two pins it can switch the output to open-drain mode, in which the pin can only pull low. It can also turn on the pin's pull-up, whatever the pin's direction. The outputs of the block are per-pin pad controls: drive value, output enable and pull-up enable. Read data is registered and appears one cycle after the read strobe.

Top module: `gpio8_port`

## Requirements
- R1: Reset (rst_n low) clears the direction register, the control register, the data latch and the read data. With reset applied, every pad_oe and pad_pu bit is 0 and bus_rdata is 0.
- R2: A write to address 0x3 loads bus_wdata into the data latch whatever the direction bits are. A pin that is an output in push-pull mode drives its latch bit on pad_out.
- R3: A read of address 0x3 returns, for each bit, the latch bit when that pin's direction bit is 1 and the synchronized pin level when it is 0. A write to the latch does not change the value read back from an input pin.
- R4: The direction register is at address 0x7. It can be read and written in full, and a 1 in a bit makes that pin an output.
- R5: The control register is at address 0xA. Bit 3 turns on open-drain mode for pin 7, bit 2 for pin 6. Bit 1 turns on the pull-up of pin 7, bit 0 that of pin 6. Bits 7 to 4 are not stored and read as 0.
- R6: For pin 6 or 7 in open-drain mode, pad_out is 0 and pad_oe equals direction AND NOT latch. Otherwise a pin is push-pull, with pad_oe equal to its direction bit and pad_out equal to its latch bit.
- R7: A write to the control register leaves the direction register unchanged.
- R8: The pull-up enables of pins 6 and 7 follow their control bits whatever the direction. Pins 0 to 5 never assert pad_pu.
- R9: A pad_in change applied before clock edge k first appears in read data captured at edge k+2.
- R10: bus_rdata loads on a clock edge where bus_re is high and holds its value on every other edge.
- R11: A read of an unmapped address returns 0. A write to an unmapped address changes no register and no pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pin levels from the pads (asynchronous) |
| pad_out | output | 8 | Drive value to the pads |
| pad_oe | output | 8 | Output enable to the pads |
| pad_pu | output | 8 | Pull-up enable to the pads |

## Verification
The data-read mux is tested with a mixed direction pattern (0x0F) against a pad pattern (0xA5). The result differs from both the latch and the pins, so choosing the wrong source for any bit shows up. Open-drain mode is tested with the top latch bits both at 0 and at 1. This separates output enables gated by the latch from plain direction, and it shows whether pad_out is forced low. Pull-ups are turned on while the top pins are inputs, to show that they do not depend on direction. A step on pad_in during a held read strobe measures the synchronizer depth exactly.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // number of upper pins that carry open-drain and pull-up control
  localparam int HI_PINS = 2;
  localparam int CTRL_W  = 2 * HI_PINS;

  // register addresses, decoded against the low bus address bits
  localparam logic [7:0] PORT_DATA_ADDR = 8'h03;
  localparam logic [7:0] PORT_DIR_ADDR  = 8'h07;
  localparam logic [7:0] PORT_CTRL_ADDR = 8'h0A;

  // control register image: open-drain enables above pull-up enables,
  // index 0 of each field belongs to the lower of the two top pins
  typedef struct packed {
    logic [HI_PINS-1:0] od;
    logic [HI_PINS-1:0] pu;
  } ctrl_t;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR,
    SEL_CTRL
  } reg_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = async_in;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        stage_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < STAGES; s++) begin
        stage_q[s] <= stage_d[s];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              we,
  output logic [WIDTH-1:0]  latch_q,
  output logic [WIDTH-1:0]  dir_q,
  output ctrl_t             ctrl_q
);

  reg_sel_e         sel;
  logic [WIDTH-1:0] latch_d;
  logic [WIDTH-1:0] dir_d;
  ctrl_t            ctrl_d;
  logic             latch_en;
  logic             dir_en;
  logic             ctrl_en;

  // address decode
  always_comb begin
    if (addr == ADDR_W'(PORT_DATA_ADDR)) begin
      sel = SEL_DATA;
    end else if (addr == ADDR_W'(PORT_DIR_ADDR)) begin
      sel = SEL_DIR;
    end else if (addr == ADDR_W'(PORT_CTRL_ADDR)) begin
      sel = SEL_CTRL;
    end else begin
      sel = SEL_NONE;
    end
  end

  // write enables per register
  always_comb begin
    latch_en = we && (sel == SEL_DATA);
    dir_en   = we && (sel == SEL_DIR);
    ctrl_en  = we && (sel == SEL_CTRL);
  end

  // next-state values
  always_comb begin
    latch_d = latch_en ? wdata : latch_q;
    dir_d   = dir_en   ? wdata : dir_q;
    ctrl_d  = ctrl_en  ? ctrl_t'(wdata[CTRL_W-1:0]) : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      ctrl_q  <= '0;
    end else begin
      latch_q <= latch_d;
      dir_q   <= dir_d;
      ctrl_q  <= ctrl_d;
    end
  end

endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] latch,
  input  logic [WIDTH-1:0] dir,
  input  ctrl_t            ctrl,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu
);

  localparam int LO_PINS = WIDTH - HI_PINS;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i >= LO_PINS) begin : g_hi
      localparam int J = i - LO_PINS;
      // open-drain: only ever sink, enable the driver when the latch is 0
      assign pad_out[i] = ctrl.od[J] ? 1'b0 : latch[i];
      assign pad_oe[i]  = ctrl.od[J] ? (dir[i] & ~latch[i]) : dir[i];
      assign pad_pu[i]  = ctrl.pu[J];
    end else begin : g_lo
      assign pad_out[i] = latch[i];
      assign pad_oe[i]  = dir[i];
      assign pad_pu[i]  = 1'b0;
    end
  end

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              re,
  input  logic [WIDTH-1:0]  latch,
  input  logic [WIDTH-1:0]  dir,
  input  ctrl_t             ctrl,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  rdata
);

  logic [WIDTH-1:0] port_view;
  logic [WIDTH-1:0] sel_val;
  logic [WIDTH-1:0] rdata_d;
  logic [WIDTH-1:0] rdata_q;

  // outputs read their latch, inputs read the synchronized pin
  always_comb begin
    port_view = (latch & dir) | (pin_sync & ~dir);
  end

  always_comb begin
    if (addr == ADDR_W'(PORT_DATA_ADDR)) begin
      sel_val = port_view;
    end else if (addr == ADDR_W'(PORT_DIR_ADDR)) begin
      sel_val = dir;
    end else if (addr == ADDR_W'(PORT_CTRL_ADDR)) begin
      sel_val = WIDTH'(ctrl);
    end else begin
      sel_val = '0;
    end
  end

  always_comb begin
    rdata_d = re ? sel_val : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/gpio8_port.sv
module gpio8_port
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_pu
);

  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] dir_q;
  ctrl_t            ctrl_q;
  logic [WIDTH-1:0] pin_sync;

  gpio_sync #(
    .WIDTH (WIDTH),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(pad_in),
    .sync_out(pin_sync)
  );

  gpio_regs #(
    .WIDTH (WIDTH),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .we     (bus_we),
    .latch_q(latch_q),
    .dir_q  (dir_q),
    .ctrl_q (ctrl_q)
  );

  gpio_pad_ctl #(
    .WIDTH(WIDTH)
  ) u_pad (
    .latch  (latch_q),
    .dir    (dir_q),
    .ctrl   (ctrl_q),
    .pad_out(pad_out),
    .pad_oe (pad_oe),
    .pad_pu (pad_pu)
  );

  gpio_rd_mux #(
    .WIDTH (WIDTH),
    .ADDR_W(ADDR_W)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (bus_addr),
    .re      (bus_re),
    .latch   (latch_q),
    .dir     (dir_q),
    .ctrl    (ctrl_q),
    .pin_sync(pin_sync),
    .rdata   (bus_rdata)
  );

endmodule

// File: rtl/gpio8_port_chk.sv
module gpio8_port_chk
  import gpio_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_pu,
  input logic [WIDTH-1:0]  latch_q,
  input logic [WIDTH-1:0]  dir_q,
  input logic [CTRL_W-1:0] ctrl_q
);

  logic a_data, a_dir, a_ctrl, a_none;
  assign a_data = (bus_addr == ADDR_W'(PORT_DATA_ADDR));
  assign a_dir  = (bus_addr == ADDR_W'(PORT_DIR_ADDR));
  assign a_ctrl = (bus_addr == ADDR_W'(PORT_CTRL_ADDR));
  assign a_none = !(a_data || a_dir || a_ctrl);

  // R2
  data_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && a_data) |=> (latch_q == $past(bus_wdata)));

  // R4
  dir_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && a_dir) |=> (bus_rdata == $past(dir_q)));

  // R5
  ctrl_rd_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && a_ctrl) |=> (bus_rdata[WIDTH-1:CTRL_W] == '0));

  // R6
  od_pin_hi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CTRL_W-1] |-> !pad_out[WIDTH-1]);

  // R6
  od_pin_lo_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[CTRL_W-2] |-> !pad_out[WIDTH-2]);

  // R7
  ctrl_keeps_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && a_ctrl) |=> $stable(dir_q));

  // R8
  pullup_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && a_ctrl) |=> (pad_pu[WIDTH-1 -: HI_PINS] == $past(bus_wdata[HI_PINS-1:0])));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));

  // R11
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && a_none) |=> (bus_rdata == '0));

  // R11
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && a_none) |=> ($stable(latch_q) && $stable(dir_q) && $stable(ctrl_q)));

endmodule

bind gpio8_port gpio8_port_chk #(
  .WIDTH (WIDTH),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_we   (bus_we),
  .bus_re   (bus_re),
  .bus_rdata(bus_rdata),
  .pad_out  (pad_out),
  .pad_pu   (pad_pu),
  .latch_q  (latch_q),
  .dir_q    (dir_q),
  .ctrl_q   (ctrl_q)
);

// File: tb/tb_gpio8_port.sv
module tb_gpio8_port;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_we;
  logic       bus_re;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;
  logic [7:0] pad_pu;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  gpio8_port dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .bus_rdata(bus_rdata),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pad_pu   (pad_pu)
  );

  typedef struct packed {
    logic       we;
    logic       re;
    logic [3:0] addr;
    logic [7:0] wdata;
    logic [7:0] exp_rd;
    logic [7:0] exp_oe;
    logic [7:0] exp_out;
    logic [7:0] exp_pu;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 15;
  // pad_in is held at 8'hA5 for the whole table
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 4'h3, 8'h3C, 8'h00, 8'h00, 8'h3C, 8'h00, 4'd2},  // R2 latch written while all inputs
    '{1'b0, 1'b1, 4'h3, 8'h00, 8'hA5, 8'h00, 8'h3C, 8'h00, 4'd3},  // R3 all inputs read pins
    '{1'b1, 1'b0, 4'h7, 8'h0F, 8'h00, 8'h0F, 8'h3C, 8'h00, 4'd4},  // R4 low nibble outputs
    '{1'b0, 1'b1, 4'h3, 8'h00, 8'hAC, 8'h0F, 8'h3C, 8'h00, 4'd3},  // R3 mixed view
    '{1'b0, 1'b1, 4'h7, 8'h00, 8'h0F, 8'h0F, 8'h3C, 8'h00, 4'd4},  // R4 direction read back
    '{1'b1, 1'b0, 4'hA, 8'hFF, 8'h00, 8'h0F, 8'h3C, 8'hC0, 4'd8},  // R8 pull-ups on input pins
    '{1'b0, 1'b1, 4'hA, 8'h00, 8'h0F, 8'h0F, 8'h3C, 8'hC0, 4'd5},  // R5 upper bits read 0
    '{1'b0, 1'b1, 4'h7, 8'h00, 8'h0F, 8'h0F, 8'h3C, 8'hC0, 4'd7},  // R7 direction kept
    '{1'b1, 1'b0, 4'h7, 8'hFF, 8'h00, 8'hFF, 8'h3C, 8'hC0, 4'd6},  // R6 od, latch 0 -> enabled
    '{1'b1, 1'b0, 4'h3, 8'hC3, 8'h00, 8'h3F, 8'h03, 8'hC0, 4'd6},  // R6 od, latch 1 -> released
    '{1'b1, 1'b0, 4'hA, 8'h01, 8'h00, 8'hFF, 8'hC3, 8'h40, 4'd6},  // R6 push-pull again
    '{1'b1, 1'b0, 4'h5, 8'hFF, 8'h00, 8'hFF, 8'hC3, 8'h40, 4'd11}, // R11 unmapped write
    '{1'b0, 1'b1, 4'h5, 8'h00, 8'h00, 8'hFF, 8'hC3, 8'h40, 4'd11}, // R11 unmapped read
    '{1'b0, 1'b1, 4'h3, 8'h00, 8'hC3, 8'hFF, 8'hC3, 8'h40, 4'd3},  // R3 all outputs read latch
    '{1'b1, 1'b0, 4'hA, 8'h08, 8'h00, 8'h7F, 8'h43, 8'h00, 4'd6}   // R6 pin 7 only open-drain
  };

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic we, input logic re, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = 8'hA5;
    repeat (3) @(negedge clk);
    // R1 reset state
    check8("R1 pad_oe in reset", pad_oe, 8'h00);
    check8("R1 pad_pu in reset", pad_pu, 8'h00);
    check8("R1 rdata in reset", bus_rdata, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      bus_cycle(VECS[k].we, VECS[k].re, VECS[k].addr, VECS[k].wdata);
      if (VECS[k].re)
        check8($sformatf("R%0d vec%0d rdata", VECS[k].req, k), bus_rdata, VECS[k].exp_rd);
      check8($sformatf("R%0d vec%0d pad_oe", VECS[k].req, k), pad_oe, VECS[k].exp_oe);
      check8($sformatf("R%0d vec%0d pad_out", VECS[k].req, k), pad_out, VECS[k].exp_out);
      check8($sformatf("R%0d vec%0d pad_pu", VECS[k].req, k), pad_pu, VECS[k].exp_pu);
    end

    // R10: last read returned C3, the write since then must not disturb it
    repeat (2) @(negedge clk);
    check8("R10 rdata hold", bus_rdata, 8'hC3);

    // R9: all inputs, then step the pads during a held read
    bus_cycle(1'b1, 1'b0, 4'h7, 8'h00);
    @(negedge clk);
    pad_in = 8'h5A; bus_re = 1'b1; bus_addr = 4'h3;
    @(negedge clk);
    check8("R9 edge k old level", bus_rdata, 8'hA5);
    @(negedge clk);
    check8("R9 edge k+1 old level", bus_rdata, 8'hA5);
    @(negedge clk);
    check8("R9 edge k+2 new level", bus_rdata, 8'h5A);
    bus_re = 1'b0;

    // R3: latch write to input pins leaves the read value alone
    bus_cycle(1'b1, 1'b0, 4'h3, 8'hFF);
    bus_cycle(1'b0, 1'b1, 4'h3, 8'h00);
    check8("R3 input read after latch write", bus_rdata, 8'h5A);

    // R1: reset in mid-run
    bus_cycle(1'b1, 1'b0, 4'h7, 8'hFF);
    bus_cycle(1'b1, 1'b0, 4'hA, 8'h0F);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check8("R1 pad_oe after reset", pad_oe, 8'h00);
    check8("R1 pad_pu after reset", pad_pu, 8'h00);
    check8("R1 rdata after reset", bus_rdata, 8'h00);
    rst_n = 1'b1;
    bus_cycle(1'b0, 1'b1, 4'h7, 8'h00);
    check8("R1 direction cleared", bus_rdata, 8'h00);
    bus_cycle(1'b0, 1'b1, 4'hA, 8'h00);
    check8("R1 control cleared", bus_rdata, 8'h00);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule